// File: doc/BRIEF.md
# Non-Blocking Cache Miss Tracker

This block keeps the bookkeeping for data-cache load misses that are still being fetched, so the core can go on hitting in the cache meanwhile. A miss to a line that is not yet outstanding takes a slot in a four-entry primary table and, in time, produces a bus request for that line. A miss to a line that already sits in the primary table is merged into a four-entry secondary table, which records only its destination tag and the primary slot it belongs to. The block never asks the bus for a merged miss.

When the bus side returns a fill for a line, the block wakes the primary miss's tag first. It then wakes each merged tag for that line in the order the tags arrived, one tag per cycle, and after that it frees the slots. A drain command stops new misses from being accepted until both tables are empty, and then a completion pulse is raised. Cache arrays, refill data and the bus protocol beyond a valid/ready request are handled elsewhere.

Top module: `missTracker`

## Requirements
- R1: Lines are 32 bytes. A line is outstanding while its primary slot is waiting or requested. An accepted miss (missValid high, stall low) whose address bits [31:5] match no outstanding line takes a primary slot. Address bits [4:0] take no part in any match.
- R2: A miss that needs a new primary slot while all four primary slots are occupied raises stall in the same cycle. It is accepted once a slot has been freed.
- R3: An accepted miss to an outstanding line takes a secondary slot and never produces a bus request of its own.
- R4: A miss to an outstanding line while all four secondary slots are occupied raises stall in the same cycle.
- R5: stall is low in every cycle in which missValid is low, so accesses that hit in the cache are never held back.
- R6: busReqValid is high while any primary slot waits to be requested. Requests are issued oldest allocation first, one per cycle of handshake, on a cycle where busReqValid and busReqReady are both high. busReqAddr holds steady while busReqValid is high and busReqReady is low, and its bits [4:0] are zero.
- R7: After a fill, wakeValid pulses carry the primary tag and then each tag merged into that line in arrival order, on consecutive cycles, one tag per cycle. Every accepted tag is woken exactly once.
- R8: fillAddr bits [4:0] are ignored. A miss to a line in the same cycle that line's fill arrives is accepted as a fresh primary miss, gets its own bus request and is not woken by that fill.
- R9: After a drainReq pulse, misses are stalled and drainDone stays low until both tables are empty. drainDone then pulses high for one cycle.
- R10: After reset, busReqValid, wakeValid, drainDone and stall are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| missValid | input | 1 | A load miss is presented this cycle |
| missAddr | input | ADDR_W (32) | Byte address of the missing load |
| missTag | input | TAG_W (5) | Destination tag returned on wakeup |
| stall | output | 1 | Miss cannot be accepted this cycle |
| busReqValid | output | 1 | A line request is offered to the bus side |
| busReqReady | input | 1 | Bus side takes the offered request |
| busReqAddr | output | ADDR_W (32) | Line-aligned address of the request |
| fillValid | input | 1 | A requested line has returned |
| fillAddr | input | ADDR_W (32) | Address of the returned line |
| wakeValid | output | 1 | A miss completes this cycle |
| wakeTag | output | TAG_W (5) | Tag of the completing miss |
| drainReq | input | 1 | Pulse: empty both tables |
| drainDone | output | 1 | One-cycle pulse once the drain has finished |

## Verification
Suppose a slot's line address or state is wrong inside the block. The first sign at the ports is a request that is repeated or missing on busReqAddr, which shows up within a cycle of the handshake. A slot whose state is lost does not show until later: it appears as a tag that is never woken, or is woken twice, once the fills are back, or as a drainDone that never arrives. A corrupted arrival order among merged misses shows up only in the order of the wakeup burst after that line's fill. The directed cases therefore compare whole wakeup bursts. The random traffic counts each tag from acceptance to wakeup and flags any line requested twice while it is outstanding.

// File: rtl/missTrackPkg.sv
package missTrackPkg;

  typedef enum logic [1:0] {
    PRIM_FREE   = 2'd0,
    PRIM_WAIT   = 2'd1,
    PRIM_PEND   = 2'd2,
    PRIM_FILLED = 2'd3
  } primStateE;

  typedef enum logic [1:0] {
    RET_IDLE = 2'd0,
    RET_PRI  = 2'd1,
    RET_SEC  = 2'd2
  } retStateE;

  // strobes from control to datapath
  typedef struct packed {
    logic allocPrim;
    logic allocSec;
    logic issue;
    logic startRet;
    logic wakePrim;
    logic wakeSec;
    logic freePrim;
  } trackStrobesT;

  // status from datapath to control
  typedef struct packed {
    logic missMatch;
    logic primFull;
    logic secFull;
    logic anyWait;
    logic anyFilled;
    logic secCand;
    logic allEmpty;
  } trackStatusT;

endpackage

// File: rtl/ageOrder.sv
module ageOrder #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [N-1:0] allocOH,
  input  logic [N-1:0] reqMask,
  output logic [N-1:0] oldestOH
);

  // olderQ[i][j] set: slot i was allocated before slot j
  logic [N-1:0] olderQ [N];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < N; i++) olderQ[i] <= '0;
    end else begin
      for (int j = 0; j < N; j++) begin
        if (allocOH[j]) begin
          for (int i = 0; i < N; i++) begin
            olderQ[j][i] <= 1'b0;
            if (i != j) olderQ[i][j] <= 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      logic beaten;
      beaten = 1'b0;
      for (int k = 0; k < N; k++) begin
        if (reqMask[k] && olderQ[k][i]) beaten = 1'b1;
      end
      oldestOH[i] = reqMask[i] && !beaten;
    end
  end

  AST_PICK_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(oldestOH)); // R6
  AST_PICK_PRESENT: assert property (@(posedge clk) disable iff (!rstN)
    (|reqMask) |-> (|oldestOH)); // R7

endmodule

// File: rtl/missTrackData.sv
module missTrackData
  import missTrackPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 5,
  parameter int PRIM_N = 4,
  parameter int SEC_N  = 4,
  parameter int OFF_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] missAddr,
  input  logic [TAG_W-1:0]  missTag,
  input  logic              fillValid,
  input  logic [ADDR_W-1:0] fillAddr,
  input  trackStrobesT      strobes,
  output trackStatusT       status,
  output logic [ADDR_W-1:0] busReqAddr,
  output logic [TAG_W-1:0]  wakeTag
);

  localparam int LINE_W = ADDR_W - OFF_W;
  localparam int PIDX_W = (PRIM_N > 1) ? $clog2(PRIM_N) : 1;

  primStateE            primStateQ [PRIM_N];
  logic [LINE_W-1:0]    primLineQ  [PRIM_N];
  logic [TAG_W-1:0]     primTagQ   [PRIM_N];
  logic [SEC_N-1:0]     secValidQ;
  logic [PIDX_W-1:0]    secLinkQ   [SEC_N];
  logic [TAG_W-1:0]     secTagQ    [SEC_N];
  logic [PIDX_W-1:0]    retIdxQ;

  logic [LINE_W-1:0] missLine, fillLine, reqLine;
  logic [PRIM_N-1:0] liveMatch, primFreeV, primAllocOH, waitMask, filledMask, fillHit, issueOH;
  logic [SEC_N-1:0]  secAllocOH, secCandMask, secOldestOH;
  logic [PIDX_W-1:0] matchIdx, filledIdx;
  logic [TAG_W-1:0]  secTagSel;

  assign missLine = missAddr[ADDR_W-1:OFF_W];
  assign fillLine = fillAddr[ADDR_W-1:OFF_W];

  // per-slot classification of the primary table
  always_comb begin
    for (int i = 0; i < PRIM_N; i++) begin
      logic live;
      live          = (primStateQ[i] == PRIM_WAIT) || (primStateQ[i] == PRIM_PEND);
      liveMatch[i]  = live && (primLineQ[i] == missLine) &&
                      !(fillValid && (fillLine == missLine));
      primFreeV[i]  = (primStateQ[i] == PRIM_FREE);
      waitMask[i]   = (primStateQ[i] == PRIM_WAIT);
      filledMask[i] = (primStateQ[i] == PRIM_FILLED);
      fillHit[i]    = fillValid && (primStateQ[i] == PRIM_PEND) && (primLineQ[i] == fillLine);
    end
  end

  // lowest free slots, matched slot and lowest filled slot
  always_comb begin
    primAllocOH = '0;
    filledIdx   = '0;
    matchIdx    = '0;
    for (int i = PRIM_N - 1; i >= 0; i--) begin
      if (primFreeV[i]) begin
        primAllocOH    = '0;
        primAllocOH[i] = 1'b1;
      end
      if (filledMask[i]) filledIdx = PIDX_W'(i);
    end
    for (int i = 0; i < PRIM_N; i++) begin
      if (liveMatch[i]) matchIdx = matchIdx | PIDX_W'(i);
    end
    secAllocOH = '0;
    for (int j = SEC_N - 1; j >= 0; j--) begin
      if (!secValidQ[j]) begin
        secAllocOH    = '0;
        secAllocOH[j] = 1'b1;
      end
    end
    for (int j = 0; j < SEC_N; j++) begin
      secCandMask[j] = secValidQ[j] && (secLinkQ[j] == retIdxQ);
    end
  end

  ageOrder #(.N(PRIM_N)) u_primAge (
    .clk      (clk),
    .rstN     (rstN),
    .allocOH  (strobes.allocPrim ? primAllocOH : '0),
    .reqMask  (waitMask),
    .oldestOH (issueOH)
  );

  ageOrder #(.N(SEC_N)) u_secAge (
    .clk      (clk),
    .rstN     (rstN),
    .allocOH  (strobes.allocSec ? secAllocOH : '0),
    .reqMask  (secCandMask),
    .oldestOH (secOldestOH)
  );

  // output muxes
  always_comb begin
    reqLine = '0;
    for (int i = 0; i < PRIM_N; i++) begin
      if (issueOH[i]) reqLine = reqLine | primLineQ[i];
    end
    secTagSel = '0;
    for (int j = 0; j < SEC_N; j++) begin
      if (secOldestOH[j]) secTagSel = secTagSel | secTagQ[j];
    end
  end

  assign busReqAddr = {reqLine, {OFF_W{1'b0}}};
  assign wakeTag    = strobes.wakePrim ? primTagQ[retIdxQ] : secTagSel;

  assign status.missMatch = |liveMatch;
  assign status.primFull  = ~|primFreeV;
  assign status.secFull   = &secValidQ;
  assign status.anyWait   = |waitMask;
  assign status.anyFilled = |filledMask;
  assign status.secCand   = |secCandMask;
  assign status.allEmpty  = (&primFreeV) && !(|secValidQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < PRIM_N; i++) begin
        primStateQ[i] <= PRIM_FREE;
        primLineQ[i]  <= '0;
        primTagQ[i]   <= '0;
      end
      for (int j = 0; j < SEC_N; j++) begin
        secLinkQ[j] <= '0;
        secTagQ[j]  <= '0;
      end
      secValidQ <= '0;
      retIdxQ   <= '0;
    end else begin
      for (int i = 0; i < PRIM_N; i++) begin
        if (strobes.allocPrim && primAllocOH[i]) begin
          primStateQ[i] <= PRIM_WAIT;
          primLineQ[i]  <= missLine;
          primTagQ[i]   <= missTag;
        end else if (strobes.issue && issueOH[i]) begin
          primStateQ[i] <= PRIM_PEND;
        end else if (fillHit[i]) begin
          primStateQ[i] <= PRIM_FILLED;
        end else if (strobes.freePrim && (retIdxQ == PIDX_W'(i))) begin
          primStateQ[i] <= PRIM_FREE;
        end
      end
      for (int j = 0; j < SEC_N; j++) begin
        if (strobes.allocSec && secAllocOH[j]) begin
          secValidQ[j] <= 1'b1;
          secLinkQ[j]  <= matchIdx;
          secTagQ[j]   <= missTag;
        end else if (strobes.wakeSec && secOldestOH[j]) begin
          secValidQ[j] <= 1'b0;
        end
      end
      if (strobes.startRet) retIdxQ <= filledIdx;
    end
  end

  AST_PRIM_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    strobes.allocPrim |-> (|primFreeV)); // R2
  AST_SEC_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    strobes.allocSec |-> !(&secValidQ)); // R4
  AST_NO_DUP_LINE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.allocPrim |-> !(|liveMatch)); // R1
  AST_SEC_LINKED: assert property (@(posedge clk) disable iff (!rstN)
    strobes.allocSec |-> $onehot(liveMatch)); // R3
  AST_FREE_FILLED: assert property (@(posedge clk) disable iff (!rstN)
    strobes.freePrim |-> (primStateQ[retIdxQ] == PRIM_FILLED)); // R7
  AST_REQ_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (status.anyWait && !strobes.issue) |=> $stable(busReqAddr)); // R6

endmodule

// File: rtl/missTrackCtrl.sv
module missTrackCtrl
  import missTrackPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         missValid,
  input  logic         busReqReady,
  input  logic         drainReq,
  input  trackStatusT  status,
  output trackStrobesT strobes,
  output logic         stall,
  output logic         busReqValid,
  output logic         wakeValid,
  output logic         drainDone
);

  retStateE retQ, retNext;
  logic     drainPendQ, drainDoneQ;
  logic     blocked, accept;

  assign blocked = drainPendQ || (status.missMatch ? status.secFull : status.primFull);
  assign stall   = missValid && blocked;
  assign accept  = missValid && !blocked;

  always_comb begin
    strobes           = '0;
    strobes.allocPrim = accept && !status.missMatch;
    strobes.allocSec  = accept && status.missMatch;
    strobes.issue     = status.anyWait && busReqReady;
    retNext           = retQ;
    unique case (retQ)
      RET_IDLE: begin
        if (status.anyFilled) begin
          strobes.startRet = 1'b1;
          retNext          = RET_PRI;
        end
      end
      RET_PRI: begin
        strobes.wakePrim = 1'b1;
        retNext          = RET_SEC;
      end
      RET_SEC: begin
        if (status.secCand) begin
          strobes.wakeSec = 1'b1;
        end else begin
          strobes.freePrim = 1'b1;
          retNext          = RET_IDLE;
        end
      end
      default: retNext = RET_IDLE;
    endcase
  end

  assign busReqValid = status.anyWait;
  assign wakeValid   = strobes.wakePrim || strobes.wakeSec;
  assign drainDone   = drainDoneQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      retQ       <= RET_IDLE;
      drainPendQ <= 1'b0;
      drainDoneQ <= 1'b0;
    end else begin
      retQ       <= retNext;
      drainPendQ <= drainReq || (drainPendQ && !status.allEmpty);
      drainDoneQ <= drainPendQ && status.allEmpty;
    end
  end

  AST_DRAIN_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    drainDone |-> status.allEmpty); // R9
  AST_DRAIN_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (drainPendQ && missValid) |-> !(strobes.allocPrim || strobes.allocSec)); // R9
  AST_WAKE_AFTER_FILL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wakeValid) |-> $past(status.anyFilled)); // R7

endmodule

// File: rtl/missTracker.sv
module missTracker
  import missTrackPkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int TAG_W      = 5,
  parameter int PRIM_N     = 4,
  parameter int SEC_N      = 4,
  parameter int LINE_BYTES = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              missValid,
  input  logic [ADDR_W-1:0] missAddr,
  input  logic [TAG_W-1:0]  missTag,
  output logic              stall,
  output logic              busReqValid,
  input  logic              busReqReady,
  output logic [ADDR_W-1:0] busReqAddr,
  input  logic              fillValid,
  input  logic [ADDR_W-1:0] fillAddr,
  output logic              wakeValid,
  output logic [TAG_W-1:0]  wakeTag,
  input  logic              drainReq,
  output logic              drainDone
);

  localparam int OFF_W = $clog2(LINE_BYTES);

  trackStrobesT strobes;
  trackStatusT  status;

  missTrackCtrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .missValid   (missValid),
    .busReqReady (busReqReady),
    .drainReq    (drainReq),
    .status      (status),
    .strobes     (strobes),
    .stall       (stall),
    .busReqValid (busReqValid),
    .wakeValid   (wakeValid),
    .drainDone   (drainDone)
  );

  missTrackData #(
    .ADDR_W (ADDR_W),
    .TAG_W  (TAG_W),
    .PRIM_N (PRIM_N),
    .SEC_N  (SEC_N),
    .OFF_W  (OFF_W)
  ) u_data (
    .clk        (clk),
    .rstN       (rstN),
    .missAddr   (missAddr),
    .missTag    (missTag),
    .fillValid  (fillValid),
    .fillAddr   (fillAddr),
    .strobes    (strobes),
    .status     (status),
    .busReqAddr (busReqAddr),
    .wakeTag    (wakeTag)
  );

endmodule

// File: tb/missTracker_tb.sv
module missTracker_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        missValid = 1'b0;
  logic [31:0] missAddr = '0;
  logic [4:0]  missTag = '0;
  logic        stall;
  logic        busReqValid;
  logic        busReqReady = 1'b0;
  logic [31:0] busReqAddr;
  logic        fillValid = 1'b0;
  logic [31:0] fillAddr = '0;
  logic        wakeValid;
  logic [4:0]  wakeTag;
  logic        drainReq = 1'b0;
  logic        drainDone;

  always #2.5 clk = ~clk;

  missTracker u_dut (
    .clk(clk), .rstN(rstN),
    .missValid(missValid), .missAddr(missAddr), .missTag(missTag), .stall(stall),
    .busReqValid(busReqValid), .busReqReady(busReqReady), .busReqAddr(busReqAddr),
    .fillValid(fillValid), .fillAddr(fillAddr),
    .wakeValid(wakeValid), .wakeTag(wakeTag),
    .drainReq(drainReq), .drainDone(drainDone)
  );

  int totalCnt = 0;
  int failCnt  = 0;
  int cyc      = 0;
  bit finished = 1'b0;
  bit rndOn    = 1'b0;
  bit inFlight [32];
  bit reqOut   [8];
  int wq[$];
  int wcq[$];
  logic [31:0] reqQ[$];
  int doneCnt = 0;
  int doneCyc = 0;

  task automatic check(input bit ok, input string rq, input longint act,
                       input longint exp, input string what);
    totalCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // port monitor, sampled half a cycle away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      if (!missValid) check(stall == 1'b0, "R5", stall, 0, "stall without miss");
      if (missValid && !stall) inFlight[missTag] = 1'b1;
      if (busReqValid && busReqReady) begin
        reqQ.push_back(busReqAddr);
        check(busReqAddr[4:0] == 5'd0, "R6", busReqAddr[4:0], 0, "request offset bits");
        if (rndOn) begin
          check(!reqOut[busReqAddr[7:5]], "R1", busReqAddr, 0, "duplicate outstanding line");
          reqOut[busReqAddr[7:5]] = 1'b1;
        end
      end
      if (wakeValid) begin
        check(inFlight[wakeTag], "R7", wakeTag, 1, "wake of tag not in flight");
        inFlight[wakeTag] = 1'b0;
        wq.push_back(int'(wakeTag));
        wcq.push_back(cyc);
      end
      if (drainDone) begin
        doneCnt++;
        doneCyc = cyc;
      end
    end
  end

  task automatic stepCycle();
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    repeat (n) stepCycle();
  endtask

  task automatic missOnce(input logic [31:0] a, input int t, output logic st);
    missValid = 1'b1;
    missAddr  = a;
    missTag   = 5'(t);
    @(negedge clk);
    st = stall;
    stepCycle();
    missValid = 1'b0;
  endtask

  task automatic missExpect(input logic [31:0] a, input int t, input logic expStall,
                            input string rq);
    logic st;
    missOnce(a, t, st);
    check(st == expStall, rq, st, expStall, $sformatf("stall for miss %0h", a));
  endtask

  task automatic fillOnce(input logic [31:0] a);
    fillValid = 1'b1;
    fillAddr  = a;
    stepCycle();
    fillValid = 1'b0;
  endtask

  function automatic bit wakesMatch(input int n, input int e0, input int e1,
                                    input int e2, input int e3);
    int e[4];
    e = '{e0, e1, e2, e3};
    if (wq.size() != n) return 1'b0;
    for (int k = 0; k < n; k++) begin
      if (wq[k] != e[k]) return 1'b0;
      if (k > 0 && wcq[k] != wcq[k-1] + 1) return 1'b0;
    end
    return 1'b1;
  endfunction

  task automatic expectWakes(input int n, input int e0, input int e1, input int e2,
                             input int e3, input string rq);
    check(wakesMatch(n, e0, e1, e2, e3), rq, (wq.size() > 0) ? wq[0] : -1, e0,
          $sformatf("wake burst of %0d tags (got %0d)", n, wq.size()));
    wq.delete();
    wcq.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      failCnt++;
      totalCnt++;
      $display("FAIL R10 watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    int wake12Cyc;
    for (int k = 0; k < 32; k++) inFlight[k] = 1'b0;
    for (int k = 0; k < 8; k++) reqOut[k] = 1'b0;

    idle(4);
    rstN = 1'b1;
    @(negedge clk);
    // R10: reset state
    check(busReqValid == 1'b0, "R10", busReqValid, 0, "busReqValid after reset");
    check(wakeValid == 1'b0, "R10", wakeValid, 0, "wakeValid after reset");
    check(drainDone == 1'b0, "R10", drainDone, 0, "drainDone after reset");
    check(stall == 1'b0, "R10", stall, 0, "stall after reset");
    stepCycle();

    // fill both tables with the bus held off
    missExpect(32'h1000, 1, 1'b0, "R1");
    missExpect(32'h1004, 2, 1'b0, "R1");   // same line, other offset: merges
    missExpect(32'h2000, 3, 1'b0, "R1");
    missExpect(32'h3000, 4, 1'b0, "R1");
    missExpect(32'h401F, 5, 1'b0, "R1");
    missExpect(32'h5000, 6, 1'b1, "R2");   // fifth distinct line
    missExpect(32'h1010, 7, 1'b0, "R3");
    missExpect(32'h2008, 8, 1'b0, "R3");
    missExpect(32'h1018, 9, 1'b0, "R3");
    missExpect(32'h3004, 10, 1'b1, "R4");  // secondary full
    @(negedge clk);
    check(stall == 1'b0, "R5", stall, 0, "stall idle with full tables");
    check(busReqValid && busReqAddr == 32'h1000, "R6", busReqAddr, 32'h1000, "oldest request offered");
    held = busReqAddr;
    idle(3);
    @(negedge clk);
    check(busReqAddr == held && busReqValid, "R6", busReqAddr, held, "request held while not ready");
    stepCycle();

    busReqReady = 1'b1;
    idle(6);
    check(reqQ.size() == 4, "R6", reqQ.size(), 4, "request count");
    if (reqQ.size() == 4) begin
      check(reqQ[0] == 32'h1000, "R6", reqQ[0], 32'h1000, "request order 0");
      check(reqQ[1] == 32'h2000, "R6", reqQ[1], 32'h2000, "request order 1");
      check(reqQ[2] == 32'h3000, "R6", reqQ[2], 32'h3000, "request order 2");
      check(reqQ[3] == 32'h4000, "R6", reqQ[3], 32'h4000, "request order 3, offset cleared");
    end
    reqQ.delete();
    @(negedge clk);
    check(busReqValid == 1'b0, "R3", busReqValid, 0, "no request for merged misses");
    stepCycle();

    // fills with offset bits set
    wq.delete(); wcq.delete();
    fillOnce(32'h101C);
    idle(8);
    expectWakes(4, 1, 2, 7, 9, "R7");
    fillOnce(32'h2008);
    idle(6);
    expectWakes(2, 3, 8, 0, 0, "R8");
    missExpect(32'h5000, 6, 1'b0, "R2");   // slot freed
    idle(3);

    // fill and fresh miss to the same line in one cycle
    busReqReady = 1'b0;
    reqQ.delete();
    fillValid = 1'b1; fillAddr = 32'h3000;
    missValid = 1'b1; missAddr = 32'h3008; missTag = 5'd11;
    @(negedge clk);
    check(stall == 1'b0, "R8", stall, 0, "same-cycle miss accepted");
    stepCycle();
    fillValid = 1'b0; missValid = 1'b0;
    @(negedge clk);
    check(busReqValid && busReqAddr == 32'h3000, "R8", busReqAddr, 32'h3000, "fresh request for refilled line");
    stepCycle();
    idle(6);
    expectWakes(1, 4, 0, 0, 0, "R8");
    busReqReady = 1'b1;
    idle(2);
    fillOnce(32'h3000);
    idle(5);
    expectWakes(1, 11, 0, 0, 0, "R8");
    fillOnce(32'h4000);
    idle(5);
    expectWakes(1, 5, 0, 0, 0, "R7");
    fillOnce(32'h5000);
    idle(5);
    expectWakes(1, 6, 0, 0, 0, "R7");

    // drain
    missExpect(32'h6000, 12, 1'b0, "R9");
    idle(2);
    drainReq = 1'b1;
    stepCycle();
    drainReq = 1'b0;
    idle(3);
    missExpect(32'h7000, 13, 1'b1, "R9");
    check(doneCnt == 0, "R9", doneCnt, 0, "drainDone while entry outstanding");
    fillOnce(32'h6000);
    idle(10);
    check(doneCnt == 1, "R9", doneCnt, 1, "single drainDone pulse");
    wake12Cyc = (wcq.size() > 0) ? wcq[0] : 1 << 30;
    check(wq.size() == 1 && wake12Cyc < doneCyc, "R9", wake12Cyc, doneCyc, "wake before drainDone");
    wq.delete(); wcq.delete();
    missExpect(32'h7000, 13, 1'b0, "R9");
    idle(2);
    fillOnce(32'h7000);
    idle(6);
    wq.delete(); wcq.delete();

    // constrained random traffic over six lines
    void'($urandom(32'd4242));
    rndOn = 1'b1;
    for (int k = 0; k < 8; k++) reqOut[k] = 1'b0;
    for (int it = 0; it < 4000; it++) begin
      int t;
      bit picked;
      int start;
      missValid   = 1'b0;
      fillValid   = 1'b0;
      busReqReady = ($urandom % 4) != 0;
      if ($urandom % 2 == 1) begin
        t = int'($urandom % 32);
        if (!inFlight[t]) begin
          missValid = 1'b1;
          missTag   = 5'(t);
          missAddr  = ((32'd1 + ($urandom % 6)) << 5) | ($urandom % 32);
        end
      end
      if ($urandom % 3 == 0) begin
        picked = 1'b0;
        start  = int'($urandom % 8);
        for (int k = 0; k < 8; k++) begin
          int idx;
          idx = (start + k) % 8;
          if (!picked && reqOut[idx]) begin
            picked    = 1'b1;
            fillValid = 1'b1;
            fillAddr  = (32'(idx) << 5) | ($urandom % 32);
            reqOut[idx] = 1'b0;
          end
        end
      end
      stepCycle();
    end

    // let everything complete
    missValid   = 1'b0;
    fillValid   = 1'b0;
    busReqReady = 1'b1;
    for (int it = 0; it < 300; it++) begin
      bit picked;
      picked    = 1'b0;
      fillValid = 1'b0;
      for (int k = 0; k < 8; k++) begin
        if (!picked && reqOut[k]) begin
          picked    = 1'b1;
          fillValid = 1'b1;
          fillAddr  = 32'(k) << 5;
          reqOut[k] = 1'b0;
        end
      end
      stepCycle();
    end
    fillValid = 1'b0;
    idle(20);
    begin
      int left;
      left = 0;
      for (int k = 0; k < 32; k++) if (inFlight[k]) left++;
      check(left == 0, "R7", left, 0, "tags never woken after random traffic");
    end
    @(negedge clk);
    check(busReqValid == 1'b0, "R6", busReqValid, 0, "no request left after random traffic");

    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
      $finish;
    end
  end

endmodule